// File: doc/BRIEF.md
# Burst-Tracking Bus Arbiter

This block decides which of several bus masters owns a shared pipelined bus with separate address and data phases. Each master raises a request line. The arbiter watches three things from the active master: the transfer type, the burst type and the shared ready line. From these it follows how far the current burst has progressed. It moves ownership only at the point where the last address beat of the burst has been accepted, so the new owner is in place during the final data-phase cycle of the old burst.

The arbiter counts the beats of fixed-length bursts itself. The owner of a fixed-length burst therefore keeps the bus even after it drops its request. An undefined-length burst has no length the arbiter can count, so ownership lasts only as long as the owner keeps its request high. When ready is low, the beat count and the ownership are both frozen. Among the requesters, the lowest index wins. Master 0 is the default owner when no master requests.

The block drives a one-hot grant vector and the encoded address-phase owner. It also drives a registered copy of the owner for the data-phase multiplexer.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released, the owner is master 0: `owner_o`=0, `grant_o`=one-hot bit 0, and `data_owner_o`=0.
- R2: At a handover, the grant goes to the requesting master with the lowest index.
- R3: At a handover with no request pending, the grant goes to the default master, index 0.
- R4: A fixed-length burst keeps its owner, whatever the request lines do, until its last beat is accepted. The handover happens on the clock edge that accepts that last beat. A BUSY transfer (trans 01) neither counts as a beat nor releases the bus in the middle of a burst.
- R5: On an edge where `hready_i` is low, no beat is counted and the owner does not change. An INCR4 burst with one stalled beat therefore hands over one cycle later than it would without the stall.
- R6: During an undefined-length burst (burst 001), the bus stays with its owner on each accepted beat for which the owner's request is high. It is handed over on the first accepted beat for which that request is low.
- R7: A SINGLE transfer (burst 000) hands over on the edge that accepts its NONSEQ (trans 10).
- R8: The burst codes give these lengths: 000 gives 1 beat and 001 gives an undefined length. 010 and 011 give 4 beats, 100 and 101 give 8 beats, and 110 and 111 give 16 beats. A beat is an accepted NONSEQ (trans 10) or SEQ (trans 11), and a NONSEQ starts a new count.
- R9: `data_owner_o` takes the value `owner_o` had before each edge where `hready_i` is high, and holds its value otherwise.
- R10: An IDLE (trans 00) accepted with `hready_i` high is a handover point.
- R11: `grant_o` is always one-hot, and its set bit is `owner_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Per-master bus requests |
| htrans_i | input | 2 | Transfer type of the active master (00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ) |
| hburst_i | input | 3 | Burst type of the active master |
| hready_i | input | 1 | Shared transfer-ready line |
| grant_o | output | N_MASTERS | One-hot grant |
| owner_o | output | IDX_W | Encoded address-phase owner |
| data_owner_o | output | IDX_W | Data-phase owner, a registered copy of `owner_o` |

## Verification
The hardest situations to reach are a handover that coincides exactly with the last counted beat of a long burst, and a burst in which stalls and BUSY cycles are mixed with the beats. A single off-by-one in the count moves the handover by one edge. To reach these cases, the bench plays the bus role cycle by cycle. It drops and raises requests in the middle of bursts, inserts ready-low and BUSY cycles, and runs full 4-, 8- and 16-beat bursts. After every edge it checks the exact edge on which ownership moves.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam int BEAT_W = 5;

  // Number of beats for a burst code; 0 marks the undefined length.
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] code);
    logic [BEAT_W-1:0] n;
    case (code[2:1])
      2'b00:   n = code[0] ? '0 : BEAT_W'(1);
      2'b01:   n = BEAT_W'(4);
      2'b10:   n = BEAT_W'(8);
      default: n = BEAT_W'(16);
    endcase
    return n;
  endfunction

  function automatic logic burst_open(input logic [2:0] code);
    return code == 3'b001;
  endfunction

endpackage

// File: rtl/arb_beat_tracker.sv
module arb_beat_tracker
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] htrans_i,
  input  logic [2:0] hburst_i,
  input  logic       hready_i,
  input  logic       owner_req_i,
  output logic       hold_o,
  output logic       beat_accept_o
);

  logic [BEAT_W-1:0] rem_q, rem_d;
  logic              open_q, open_d;
  logic [BEAT_W-1:0] new_len;
  trans_e            tr;

  assign tr      = trans_e'(htrans_i);
  assign new_len = burst_beats(hburst_i);
  assign beat_accept_o = hready_i && (tr == TR_NONSEQ || tr == TR_SEQ);

  // Does the current owner keep the bus past this edge?
  always_comb begin
    case (tr)
      TR_NONSEQ: hold_o = burst_open(hburst_i) ? owner_req_i : (new_len > BEAT_W'(1));
      TR_SEQ:    hold_o = open_q ? owner_req_i : (rem_q > BEAT_W'(1));
      TR_BUSY:   hold_o = open_q ? owner_req_i : (rem_q != '0);
      default:   hold_o = 1'b0;
    endcase
  end

  always_comb begin
    rem_d  = rem_q;
    open_d = open_q;
    if (hready_i) begin
      case (tr)
        TR_NONSEQ: begin
          open_d = burst_open(hburst_i);
          rem_d  = (new_len != '0) ? new_len - BEAT_W'(1) : '0;
        end
        TR_SEQ:  rem_d = (rem_q != '0) ? rem_q - BEAT_W'(1) : '0;
        TR_IDLE: begin
          rem_d  = '0;
          open_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      open_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic [IDX_W-1:0]     winner_o,
  output logic                 any_o
);

  always_comb begin
    winner_o = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (req_i[i]) winner_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/arb_owner_regs.sv
module arb_owner_regs #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hready_i,
  input  logic                 handover_i,
  input  logic [IDX_W-1:0]     next_owner_i,
  output logic [IDX_W-1:0]     owner_o,
  output logic [IDX_W-1:0]     data_owner_o,
  output logic [N_MASTERS-1:0] grant_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_o      <= '0;
      data_owner_o <= '0;
    end else if (hready_i) begin
      data_owner_o <= owner_o;
      if (handover_i) owner_o <= next_owner_i;
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
    assign grant_o[g] = (owner_o == IDX_W'(g));
  end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [1:0]           htrans_i,
  input  logic [2:0]           hburst_i,
  input  logic                 hready_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [IDX_W-1:0]     owner_o,
  output logic [IDX_W-1:0]     data_owner_o
);

  logic             burst_hold;
  logic             beat_accept;
  logic             owner_req;
  logic             handover;
  logic             any_req;
  logic [IDX_W-1:0] winner;

  assign owner_req = req_i[owner_o];
  assign handover  = hready_i && !burst_hold;

  arb_beat_tracker u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .htrans_i      (htrans_i),
    .hburst_i      (hburst_i),
    .hready_i      (hready_i),
    .owner_req_i   (owner_req),
    .hold_o        (burst_hold),
    .beat_accept_o (beat_accept)
  );

  arb_prio_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req_i    (req_i),
    .winner_o (winner),
    .any_o    (any_req)
  );

  arb_owner_regs #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .hready_i     (hready_i),
    .handover_i   (handover),
    .next_owner_i (any_req ? winner : '0),
    .owner_o      (owner_o),
    .data_owner_o (data_owner_o),
    .grant_o      (grant_o)
  );

endmodule

// File: rtl/arb_checks.sv
module arb_checks #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_i,
  input logic [1:0]           htrans_i,
  input logic                 hready_i,
  input logic [N_MASTERS-1:0] grant_o,
  input logic [IDX_W-1:0]     owner_o,
  input logic [IDX_W-1:0]     data_owner_o,
  input logic                 hold
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1 && grant_o[owner_o]); // R11

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(owner_o)); // R5

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hready_i && hold |=> $stable(owner_o)); // R4

  AST_DATA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hready_i |=> data_owner_o == $past(owner_o)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(data_owner_o)); // R9

  AST_DEFAULT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    hready_i && htrans_i == 2'b00 && req_i == '0 |=> owner_o == '0); // R3

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hready_i && !hold && req_i != '0 |=> grant_o == $past(req_i & (~req_i + 1'b1))); // R2

endmodule

bind bus_grant_arbiter arb_checks #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_arb_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .htrans_i     (htrans_i),
  .hready_i     (hready_i),
  .grant_o      (grant_o),
  .owner_o      (owner_o),
  .data_owner_o (data_owner_o),
  .hold         (burst_hold)
);

// File: tb/test_bus_grant_arbiter.sv
module test_bus_grant_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NROWS = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] req = '0;
  logic [1:0]    htrans = 2'b00;
  logic [2:0]    hburst = 3'b000;
  logic          hready = 1'b1;
  logic [NM-1:0] grant;
  logic [1:0]    owner;
  logic [1:0]    downer;

  int checks = 0;
  int failures = 0;

  bus_grant_arbiter #(.N_MASTERS(NM)) i_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .htrans_i(htrans),
    .hburst_i(hburst), .hready_i(hready), .grant_o(grant),
    .owner_o(owner), .data_owner_o(downer)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {req, trans, burst, ready, expected owner, expected data owner, requirement}
  localparam logic [17:0] VEC [NROWS] = '{
    {4'b0010, 2'd0, 3'd0, 1'b1, 2'd1, 2'd0, 4'd2},  // R2 idle handover to 1 (R10)
    {4'b0010, 2'd2, 3'd3, 1'b1, 2'd1, 2'd1, 4'd4},  // R4 INCR4 start
    {4'b0000, 2'd3, 3'd3, 1'b1, 2'd1, 2'd1, 4'd4},  // R4 request dropped, still held
    {4'b0001, 2'd3, 3'd3, 1'b0, 2'd1, 2'd1, 4'd5},  // R5 stall
    {4'b0001, 2'd3, 3'd3, 1'b1, 2'd1, 2'd1, 4'd5},  // R5 third beat
    {4'b0001, 2'd3, 3'd3, 1'b1, 2'd0, 2'd1, 4'd4},  // R4 last beat: handover
    {4'b0101, 2'd0, 3'd0, 1'b1, 2'd0, 2'd0, 4'd2},  // R2 lowest of 0 and 2
    {4'b0100, 2'd0, 3'd0, 1'b1, 2'd2, 2'd0, 4'd10}, // R10 idle handover
    {4'b0100, 2'd2, 3'd1, 1'b1, 2'd2, 2'd2, 4'd6},  // R6 INCR start, held by request
    {4'b0101, 2'd3, 3'd1, 1'b1, 2'd2, 2'd2, 4'd6},  // R6 higher priority waits
    {4'b0001, 2'd3, 3'd1, 1'b1, 2'd0, 2'd2, 4'd6},  // R6 request low: released
    {4'b1000, 2'd2, 3'd0, 1'b1, 2'd3, 2'd0, 4'd7},  // R7 single hands over at once
    {4'b0000, 2'd0, 3'd0, 1'b0, 2'd3, 2'd0, 4'd9},  // R9 stall holds both
    {4'b0000, 2'd0, 3'd0, 1'b1, 2'd0, 2'd3, 4'd3},  // R3 default master
    {4'b0010, 2'd2, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 WRAP8 start
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 2
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 3
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 4
    {4'b0010, 2'd1, 3'd4, 1'b1, 2'd0, 2'd0, 4'd4},  // R4 BUSY mid-burst
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 5
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 6
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 beat 7
    {4'b0010, 2'd3, 3'd4, 1'b1, 2'd1, 2'd0, 4'd8},  // R8 beat 8: handover
    {4'b0000, 2'd0, 3'd0, 1'b1, 2'd0, 2'd1, 4'd3}   // R3 back to default
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_grant(input string tag);
    check({tag, " grant one-hot (R11)"}, int'(grant), 1 << owner);
  endtask

  task automatic step(input logic [NM-1:0] r, input logic [1:0] t,
                      input logic [2:0] b, input logic rdy);
    req = r; htrans = t; hburst = b; hready = rdy;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 owner in reset", owner, 0);
    check("R1 data owner in reset", downer, 0);
    check("R1 grant in reset", grant, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[i][3:0], i);
      step(VEC[i][17:14], VEC[i][13:12], VEC[i][11:9], VEC[i][8]);
      check({tag, " owner"}, owner, VEC[i][7:6]);
      check({tag, " data owner"}, downer, VEC[i][5:4]);
      check_grant(tag);
    end

    // R8 INCR16: sixteen accepted beats before handover to master 1
    step(4'b0010, 2'd2, 3'd7, 1'b1);
    check("R8 INCR16 beat 1 held", owner, 0);
    for (int k = 2; k <= 15; k++) begin
      step(4'b0010, 2'd3, 3'd7, 1'b1);
      check($sformatf("R8 INCR16 beat %0d held", k), owner, 0);
    end
    step(4'b0010, 2'd3, 3'd7, 1'b1);
    check("R8 INCR16 beat 16 handover", owner, 1);
    check_grant("R8 INCR16");

    // R8 WRAP4 owned by master 1: four beats, then handover to master 3
    step(4'b1000, 2'd2, 3'd2, 1'b1);
    check("R8 WRAP4 beat 1 held", owner, 1);
    step(4'b1000, 2'd3, 3'd2, 1'b1);
    step(4'b1000, 2'd3, 3'd2, 1'b1);
    check("R8 WRAP4 beat 3 held", owner, 1);
    step(4'b1000, 2'd3, 3'd2, 1'b1);
    check("R8 WRAP4 beat 4 handover", owner, 3);

    // R5 stall on the last beat delays the handover
    step(4'b0001, 2'd2, 3'd0, 1'b0);
    check("R5 stalled single keeps owner", owner, 3);
    step(4'b0001, 2'd2, 3'd0, 1'b1);
    check("R7 single accepted hands over", owner, 0);
    check("R9 data owner after handover", downer, 3);

    // R1 reset in the middle of ownership
    step(4'b0100, 2'd0, 3'd0, 1'b1);
    check("R10 idle handover to 2", owner, 2);
    rst_n = 1'b0;
    #1;
    check("R1 owner after async reset", owner, 0);
    check("R1 data owner after async reset", downer, 0);
    check("R1 grant after async reset", grant, 1);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0000, 2'd0, 3'd0, 1'b1);
    check("R3 default after reset release", owner, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule